// File: doc/BRIEF.md
# Second-Operand Shifter

This block forms the second operand that a data-processing datapath hands to its ALU, together with the carry that the shifter produces. The first operand bypasses it. The block takes a 12-bit operand field, a bit that selects the immediate form, the value of the source register and the value of the register that can hold a shift amount. It also takes the current carry flag. It returns a 32-bit operand and a carry-out. The block has no clock and no state.

The block supports three forms. The rotated-immediate form rotates an 8-bit constant right by twice a 4-bit field. The immediate-shift form shifts the register value by a 5-bit amount taken from the operand field. The register-shift form takes its amount from the low byte of the amount register, so amounts from 0 to 255 are handled. Four shift kinds are available. An immediate amount of zero is read specially for some kinds, so that a shift of 32 and a one-bit rotate through carry can be encoded.

Top module: `bs_operand2`

## Requirements
- R1: With `imm_sel_i` = 1, `operand_o` is `op_field_i[7:0]` zero-extended to 32 bits and rotated right by 2 × `op_field_i[11:8]` positions.
- R2: With `imm_sel_i` = 1, `carry_o` equals `operand_o[31]` when `op_field_i[11:8]` is non-zero, and equals `carry_i` when it is zero.
- R3: With `imm_sel_i` = 0, `op_field_i[6:5]` selects the shift kind: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right. `op_field_i[4]` = 0 selects an amount taken from `op_field_i[11:7]`. `op_field_i[4]` = 1 selects an amount taken from `rs_val_i[7:0]`. `op_field_i[3:0]` and `rs_val_i[31:8]` have no effect.
- R4: An immediate amount of 0 with logical left passes `rm_val_i` through unchanged and keeps `carry_i`. The same amount with logical right or arithmetic right means a shift by 32.
- R5: An immediate amount of 0 with rotate right gives `{carry_i, rm_val_i[31:1]}`, and `carry_o` = `rm_val_i[0]`.
- R6: A register amount of 0 passes `rm_val_i` through unchanged and keeps `carry_i`, for every shift kind.
- R7: A logical shift of 32 gives 0, with `carry_o` = `rm_val_i[0]` for a left shift and `rm_val_i[31]` for a right shift. A logical shift above 32 gives 0 with `carry_o` = 0.
- R8: An arithmetic right shift of 32 or more fills every bit with `rm_val_i[31]` and sets `carry_o` = `rm_val_i[31]`.
- R9: For a shift of 1 to 31 by any kind, `carry_o` is the last bit shifted out. A register rotate by a non-zero multiple of 32 returns `rm_val_i` unchanged, with `carry_o` = `rm_val_i[31]`. Any other register rotate amount rotates by its low 5 bits.
- R10: Both outputs depend only on the present inputs, with no clock and no stored state. All inputs at zero give a zero operand and a zero carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_field_i | input | 12 | Operand field of the instruction |
| imm_sel_i | input | 1 | 1 selects the rotated-immediate form |
| rm_val_i | input | 32 | Value of the register to be shifted |
| rs_val_i | input | 32 | Value of the register that holds the shift amount (low byte used) |
| carry_i | input | 1 | Current carry flag |
| operand_o | output | 32 | Second ALU operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The block holds no state, so a fault in its internal decode shows at the ports at once. The effect appears in the same cycle as the input that exercises it, and it disappears when the inputs change. A wrong reading of the zero-amount encodings shows as a result that is off by exactly one shift, or as a carry that ignores `carry_i`. A wrong amount clamp shows only for amounts of 32 and above, so the stimulus puts extra weight on register amounts of 31, 32, 33, 64 and 255. It also drives the bits that have no effect with random values.

// File: rtl/bs_operand2_pkg.sv
package bs_operand2_pkg;

  localparam int unsigned XLEN      = 32;
  localparam int unsigned FIELD_W   = 12;
  localparam int unsigned IMM_W     = 8;
  localparam int unsigned ROT_W     = 4;
  localparam int unsigned SH_AMT_W  = 5;
  localparam int unsigned REG_AMT_W = 8;

  // field positions the decode depends on
  localparam int unsigned ROT_LSB    = IMM_W;
  localparam int unsigned SH_AMT_LSB = 7;
  localparam int unsigned KIND_LSB   = 5;
  localparam int unsigned REGSH_BIT  = 4;

  typedef enum logic [1:0] {
    SK_LSL = 2'b00,
    SK_LSR = 2'b01,
    SK_ASR = 2'b10,
    SK_ROR = 2'b11
  } shift_kind_e;

endpackage

// File: rtl/bs_rot_imm.sv
module bs_rot_imm #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IMM_W = 8,
  parameter int unsigned ROT_W = 4
) (
  input  logic [IMM_W-1:0] imm_i,
  input  logic [ROT_W-1:0] rot_i,
  input  logic             carry_i,
  output logic [XLEN-1:0]  val_o,
  output logic             carry_o
);
  localparam int unsigned LG = $clog2(XLEN);

  logic [XLEN-1:0] ext;
  logic [LG-1:0]   rot_amt;

  assign ext     = {{(XLEN-IMM_W){1'b0}}, imm_i};
  assign rot_amt = LG'({rot_i, 1'b0});

  // per-bit source select: result bit i takes bit (i+rot) mod XLEN
  for (genvar i = 0; i < XLEN; i++) begin : g_bit
    logic [LG-1:0] src;
    assign src      = LG'(i) + rot_amt;
    assign val_o[i] = ext[src];
  end

  assign carry_o = (rot_i == '0) ? carry_i : val_o[XLEN-1];

endmodule

// File: rtl/bs_amt_sel.sv
module bs_amt_sel
  import bs_operand2_pkg::*;
#(
  parameter int unsigned SH_AMT_W  = 5,
  parameter int unsigned REG_AMT_W = 8
) (
  input  logic [SH_AMT_W-1:0]  sh_amt_i,
  input  logic [1:0]           kind_i,
  input  logic                 reg_sh_i,
  input  logic [REG_AMT_W-1:0] rs_amt_i,
  output shift_kind_e          kind_o,
  output logic [REG_AMT_W-1:0] amt_o,
  output logic                 rrx_o
);
  localparam logic [REG_AMT_W-1:0] FULL = REG_AMT_W'(1 << SH_AMT_W);

  always_comb begin
    kind_o = shift_kind_e'(kind_i);
    rrx_o  = 1'b0;
    if (reg_sh_i) begin
      amt_o = rs_amt_i;
    end else begin
      amt_o = REG_AMT_W'(sh_amt_i);
      if (sh_amt_i == '0) begin
        unique case (kind_o)
          SK_LSR, SK_ASR: amt_o = FULL;
          SK_ROR:         rrx_o = 1'b1;
          default:        amt_o = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/bs_shift_core.sv
module bs_shift_core
  import bs_operand2_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned AMT_W = 8
) (
  input  logic [XLEN-1:0]  val_i,
  input  shift_kind_e      kind_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic             rrx_i,
  input  logic             carry_i,
  output logic [XLEN-1:0]  res_o,
  output logic             carry_o
);
  localparam int unsigned LG = $clog2(XLEN);

  logic [XLEN:0]        lsl_w, lsr_w;
  logic signed [XLEN:0] asr_w;
  logic [XLEN-1:0]      ror_v;
  logic [LG-1:0]        ror_r;
  int unsigned          a_log, a_ari;

  always_comb begin
    a_log = int'(amt_i);
    if (a_log > XLEN) a_log = XLEN + 1;
    a_ari = (a_log > XLEN) ? XLEN : a_log;
    lsl_w = {1'b0, val_i} << a_log;
    lsr_w = {val_i, 1'b0} >> a_log;
    asr_w = $signed({val_i, 1'b0}) >>> a_ari;
    ror_r = amt_i[LG-1:0];
    ror_v = (val_i >> ror_r) | (val_i << (XLEN - int'(ror_r)));
  end

  always_comb begin
    res_o   = val_i;
    carry_o = carry_i;
    if (rrx_i) begin
      res_o   = {carry_i, val_i[XLEN-1:1]};
      carry_o = val_i[0];
    end else if (amt_i != '0) begin
      unique case (kind_i)
        SK_LSL: {carry_o, res_o} = lsl_w;
        SK_LSR: {res_o, carry_o} = lsr_w;
        SK_ASR: {res_o, carry_o} = asr_w;
        default: begin
          res_o   = ror_v;
          carry_o = ror_v[XLEN-1];
        end
      endcase
    end
  end

endmodule

// File: rtl/bs_operand2.sv
module bs_operand2
  import bs_operand2_pkg::*;
(
  input  logic [FIELD_W-1:0] op_field_i,
  input  logic               imm_sel_i,
  input  logic [XLEN-1:0]    rm_val_i,
  input  logic [XLEN-1:0]    rs_val_i,
  input  logic               carry_i,
  output logic [XLEN-1:0]    operand_o,
  output logic               carry_o
);
  logic [XLEN-1:0]      imm_val, sh_val;
  logic                 imm_c, sh_c, rrx;
  shift_kind_e          kind;
  logic [REG_AMT_W-1:0] amt;
  logic                 unused_bits;

  assign unused_bits = ^{op_field_i[REGSH_BIT-1:0], rs_val_i[XLEN-1:REG_AMT_W]};

  bs_rot_imm #(.XLEN(XLEN), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_rot (
    .imm_i   (op_field_i[IMM_W-1:0]),
    .rot_i   (op_field_i[ROT_LSB +: ROT_W]),
    .carry_i (carry_i),
    .val_o   (imm_val),
    .carry_o (imm_c)
  );

  bs_amt_sel #(.SH_AMT_W(SH_AMT_W), .REG_AMT_W(REG_AMT_W)) u_sel (
    .sh_amt_i (op_field_i[SH_AMT_LSB +: SH_AMT_W]),
    .kind_i   (op_field_i[KIND_LSB +: 2]),
    .reg_sh_i (op_field_i[REGSH_BIT]),
    .rs_amt_i (rs_val_i[REG_AMT_W-1:0]),
    .kind_o   (kind),
    .amt_o    (amt),
    .rrx_o    (rrx)
  );

  bs_shift_core #(.XLEN(XLEN), .AMT_W(REG_AMT_W)) u_core (
    .val_i   (rm_val_i),
    .kind_i  (kind),
    .amt_i   (amt),
    .rrx_i   (rrx),
    .carry_i (carry_i),
    .res_o   (sh_val),
    .carry_o (sh_c)
  );

  assign operand_o = imm_sel_i ? imm_val : sh_val;
  assign carry_o   = imm_sel_i ? imm_c   : sh_c;

  always_comb begin
    if (imm_sel_i) begin
      assert_imm_ones_R1: assert ($countones(operand_o) == $countones(op_field_i[IMM_W-1:0]))
        else $error("rotated immediate lost bits");
      if (op_field_i[ROT_LSB +: ROT_W] != '0) begin
        assert_imm_carry_R2: assert (carry_o == operand_o[XLEN-1])
          else $error("immediate carry not bit 31");
      end else begin
        assert_imm_norot_R2: assert (carry_o == carry_i && operand_o == XLEN'(op_field_i[IMM_W-1:0]))
          else $error("unrotated immediate wrong");
      end
    end else if (op_field_i[REGSH_BIT]) begin
      if (rs_val_i[REG_AMT_W-1:0] == '0) begin
        assert_reg_zero_R6: assert (operand_o == rm_val_i && carry_o == carry_i)
          else $error("zero register amount altered value");
      end
      if (rs_val_i[REG_AMT_W-1:0] > REG_AMT_W'(XLEN) && !op_field_i[KIND_LSB+1]) begin
        assert_logic_over_R7: assert (operand_o == '0 && !carry_o)
          else $error("logical overshift not cleared");
      end
      if (rs_val_i[REG_AMT_W-1:0] >= REG_AMT_W'(XLEN) && op_field_i[KIND_LSB +: 2] == SK_ASR) begin
        assert_asr_fill_R8: assert (operand_o == {XLEN{rm_val_i[XLEN-1]}} && carry_o == rm_val_i[XLEN-1])
          else $error("arithmetic overshift not sign filled");
      end
    end else if (op_field_i[SH_AMT_LSB +: SH_AMT_W] == '0 && op_field_i[KIND_LSB +: 2] == SK_ROR) begin
      assert_rrx_R5: assert (operand_o[XLEN-2:0] == rm_val_i[XLEN-1:1] && carry_o == rm_val_i[0])
        else $error("rotate through carry wrong");
    end
  end

endmodule

// File: tb/sim_bs_operand2.sv
module sim_bs_operand2;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] op_field;
  logic        imm_sel;
  logic [31:0] rm_val, rs_val;
  logic        carry_in;
  logic [31:0] operand;
  logic        carry_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bs_operand2 u0 (
    .op_field_i (op_field),
    .imm_sel_i  (imm_sel),
    .rm_val_i   (rm_val),
    .rs_val_i   (rs_val),
    .carry_i    (carry_in),
    .operand_o  (operand),
    .carry_o    (carry_out)
  );

  // behavioural model: one position per step
  task automatic model(output logic [31:0] v, output logic c);
    int amt;
    int kind;
    v = rm_val;
    c = carry_in;
    if (imm_sel) begin
      v = {24'd0, op_field[7:0]};
      for (int i = 0; i < 2 * op_field[11:8]; i++) v = {v[0], v[31:1]};
      if (op_field[11:8] != 0) c = v[31];
      return;
    end
    kind = op_field[6:5];
    if (op_field[4]) amt = rs_val[7:0];
    else begin
      amt = op_field[11:7];
      if (amt == 0 && (kind == 1 || kind == 2)) amt = 32;
      if (amt == 0 && kind == 3) begin
        c = rm_val[0];
        v = {carry_in, rm_val[31:1]};
        return;
      end
    end
    for (int i = 0; i < amt; i++) begin
      case (kind)
        0: begin c = v[31]; v = v << 1; end
        1: begin c = v[0];  v = v >> 1; end
        2: begin c = v[0];  v = {v[31], v[31:1]}; end
        default: begin c = v[0]; v = {v[0], v[31:1]}; end
      endcase
    end
  endtask

  function automatic string tag_of();
    if (imm_sel) return (op_field[11:8] == 0) ? "R2" : "R1";
    if (!op_field[4]) begin
      if (op_field[11:7] == 0) return (op_field[6:5] == 3) ? "R5" : "R4";
      return "R3";
    end
    if (rs_val[7:0] == 0) return "R6";
    if (rs_val[7:0] >= 32 && op_field[6:5] < 2) return "R7";
    if (rs_val[7:0] >= 32 && op_field[6:5] == 2) return "R8";
    return "R9";
  endfunction

  task automatic apply(input logic [11:0] f, input logic is, input logic [31:0] m,
                       input logic [31:0] s, input logic ci, input string tag);
    logic [31:0] ev;
    logic ec;
    @(posedge clk);
    op_field = f; imm_sel = is; rm_val = m; rs_val = s; carry_in = ci;
    @(negedge clk);
    model(ev, ec);
    checks++;
    if (operand !== ev || carry_out !== ec) begin
      errors++;
      $display("FAIL %s field=%h imm=%b rm=%h rs=%h cin=%b : got %h/%b expected %h/%b",
               (tag == "") ? tag_of() : tag, f, is, m, s, ci, operand, carry_out, ev, ec);
    end
  endtask

  function automatic logic [11:0] regf(input int kind);
    return {4'h3, 1'b0, 2'(kind), 1'b1, 4'ha};
  endfunction

  initial begin
    op_field = '0; imm_sel = 0; rm_val = '0; rs_val = '0; carry_in = 0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // R10: all-zero inputs give zero outputs
    apply(12'h000, 0, 32'h0, 32'h0, 0, "R10");
    // R1 / R2 rotated immediates
    apply(12'h0ff, 1, 32'h1234, 0, 1, "R2");
    apply(12'h1ff, 1, 0, 0, 0, "R1");
    apply(12'h4ab, 1, 0, 0, 1, "R1");
    apply(12'hf01, 1, 0, 0, 0, "R2");
    apply(12'h180, 1, 0, 0, 1, "R2");
    // R3 immediate shifts, junk in the ignored fields
    apply({5'd4, 2'd0, 1'b0, 4'hf}, 0, 32'h8000_0001, 32'hffff_ff00, 0, "R3");
    apply({5'd31, 2'd1, 1'b0, 4'h5}, 0, 32'h8000_0000, 32'hdead_beef, 0, "R3");
    apply({5'd1, 2'd2, 1'b0, 4'h0}, 0, 32'h8000_0003, 0, 0, "R9");
    apply({5'd8, 2'd3, 1'b0, 4'h0}, 0, 32'h0000_0080, 0, 0, "R9");
    // R4 / R5 zero-amount encodings
    apply({5'd0, 2'd0, 1'b0, 4'h0}, 0, 32'hcafe_f00d, 0, 1, "R4");
    apply({5'd0, 2'd1, 1'b0, 4'h0}, 0, 32'h8000_0000, 0, 0, "R4");
    apply({5'd0, 2'd2, 1'b0, 4'h0}, 0, 32'h8000_0000, 0, 0, "R4");
    apply({5'd0, 2'd3, 1'b0, 4'h0}, 0, 32'h0000_0003, 0, 1, "R5");
    apply({5'd0, 2'd3, 1'b0, 4'h0}, 0, 32'h0000_0002, 0, 0, "R5");
    // R6 zero register amount, upper rs bits set
    for (int k = 0; k < 4; k++) apply(regf(k), 0, 32'h9abc_def1, 32'hffff_ff00, k[0], "R6");
    // R7 / R8 / R9 register amounts around the boundaries
    apply(regf(0), 0, 32'h0000_0001, 32'd32, 0, "R7");
    apply(regf(1), 0, 32'h8000_0000, 32'd32, 0, "R7");
    apply(regf(0), 0, 32'hffff_ffff, 32'd33, 1, "R7");
    apply(regf(1), 0, 32'hffff_ffff, 32'd255, 1, "R7");
    apply(regf(2), 0, 32'h8000_0000, 32'd40, 0, "R8");
    apply(regf(2), 0, 32'h7fff_ffff, 32'd32, 1, "R8");
    apply(regf(3), 0, 32'h8000_0001, 32'd64, 0, "R9");
    apply(regf(3), 0, 32'h0000_0010, 32'd37, 0, "R9");
    apply(regf(0), 0, 32'h4000_0000, 32'd31, 0, "R9");
    // mixed patterns
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] s;
      s = $urandom;
      case ($urandom_range(0, 7))
        0: s[7:0] = 8'd0;
        1: s[7:0] = 8'd31;
        2: s[7:0] = 8'd32;
        3: s[7:0] = 8'd33;
        4: s[7:0] = 8'd64;
        5: s[7:0] = 8'd255;
        default: ;
      endcase
      apply(12'($urandom), 1'($urandom), $urandom, s, 1'($urandom), "");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      checks++;
      errors++;
      $display("FAIL R10 watchdog expired: got %0d cycles expected at most %0d", cycles, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule